// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block turns a write to the software interrupt trigger register into per-processor set-pending updates. The written word names one of the sixteen software interrupt numbers and selects its targets through a two-bit filter field: an explicit target list, every online processor except the sender, or the sender alone. The fourth filter encoding is reserved and the write is discarded. For every processor that is targeted, the block raises that processor's pending flag for the interrupt and ORs the sender's bit into the interrupt's per-processor source mask.

The block is built around a two-state machine. `ST_IDLE` waits for an accepted write. The transition `GO_ISSUE` (accepted write while idle) and `STAY_ISSUE` (accepted write while issuing) load the decoded target set and enter `ST_ISSUE`. In `ST_ISSUE` the strobes are driven for one cycle and all targeted processors' flags are written at the end of that cycle. The transition `BACK_IDLE` returns to `ST_IDLE` when no new write was accepted. The stored pending flags and source masks are visible on a combinational readback port addressed by processor and interrupt number. Prioritising and delivering the interrupts belong to other blocks.

Top module: `sgi_dispatch`

## Requirements
- R1: The interrupt number is bits [3:0] of the written word and appears on `set_pend_id` in the cycle after the write.
- R2: With filter bits [25:24] equal to 0, the targets are the list in bits [23:16], bit n selecting processor n.
- R3: With filter value 1, the targets are all processors with index below `online_cnt`, except the sender `src_cpu`.
- R4: With filter value 2, the only target is the sender.
- R5: With filter value 3 the write is dropped: no strobe is raised and no stored flag or source mask changes.
- R6: For each target, the interrupt's pending flag becomes 1 and bit `src_cpu` is ORed into its source mask; earlier source bits are kept. `src_upd` carries the sender's one-hot bit with every strobe.
- R7: A write with `wr_full` low (not a 32-bit access) has no effect.
- R8: The trigger register reads as zero: `trig_rdata` is always 0.
- R9: Target bits for processors at or above `online_cnt` are ignored under every filter.
- R10: Every targeted processor receives its strobe in the same cycle, and the flags of all of them are visible on the readback port one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write to the trigger register |
| wr_full | input | 1 | Write is a full 32-bit access |
| wr_data | input | 32 | Written word |
| src_cpu | input | CPU_W | Index of the writing processor |
| online_cnt | input | CNT_W | Number of online processors |
| trig_rdata | output | 32 | Read value of the trigger register |
| set_pend_vld | output | NUM_CPU | Per-processor set-pending strobe |
| set_pend_id | output | 4 | Interrupt number carried by the strobes |
| src_upd | output | NUM_CPU | One-hot sender bit to OR into source masks |
| rb_cpu | input | CPU_W | Readback processor index |
| rb_sgi | input | 4 | Readback interrupt number |
| rb_pend | output | 1 | Stored pending flag |
| rb_src | output | NUM_CPU | Stored source mask |

## Verification
The bench builds the block with its defaults, eight processors and sixteen interrupts, so the full eight-bit target list and every sender index are reachable. Varying `online_cnt` between four, five and eight exposes the masking of offline targets under the explicit list and the all-but-self filter. Repeated triggers of one interrupt from different senders make the source-mask accumulation observable.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
    typedef enum logic [1:0] {
        FLT_LIST   = 2'd0,
        FLT_OTHERS = 2'd1,
        FLT_SELF   = 2'd2,
        FLT_RSVD   = 2'd3
    } sgi_filter_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } sgi_state_e;

    localparam int ID_W   = 4;
    localparam int ID_LSB = 0;
    localparam int TL_LSB = 16;
    localparam int FL_LSB = 24;
endpackage

// File: rtl/sgi_tgt_decode.sv
module sgi_tgt_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
    input  logic [31:0]        word_i,
    input  logic [CPU_W-1:0]   src_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [NUM_CPU-1:0] tgt_o,
    output logic [ID_W-1:0]    id_o,
    output logic               drop_o
);
    logic [NUM_CPU-1:0] online;
    logic [NUM_CPU-1:0] self_bit;
    sgi_filter_e        flt;

    assign flt  = sgi_filter_e'(word_i[FL_LSB +: 2]);
    assign id_o = word_i[ID_LSB +: ID_W];

    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            online[i]   = (CNT_W'(i) < cnt_i);
            self_bit[i] = (CPU_W'(i) == src_i);
        end
    end

    always_comb begin
        drop_o = 1'b0;
        unique case (flt)
            FLT_LIST:   tgt_o = word_i[TL_LSB +: NUM_CPU] & online;
            FLT_OTHERS: tgt_o = online & ~self_bit;
            FLT_SELF:   tgt_o = self_bit & online;
            default: begin
                tgt_o  = '0;
                drop_o = 1'b1;
            end
        endcase
    end

    always_comb begin
        p_online_only_r9: assert ((tgt_o & ~online) == '0);
    end
endmodule

// File: rtl/sgi_flag_store.sv
module sgi_flag_store
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] set_vld_i,
    input  logic [ID_W-1:0]    set_id_i,
    input  logic [NUM_CPU-1:0] src_i,
    input  logic [CPU_W-1:0]   rb_cpu_i,
    input  logic [ID_W-1:0]    rb_sgi_i,
    output logic               rb_pend_o,
    output logic [NUM_CPU-1:0] rb_src_o
);
    logic [NUM_SGI-1:0] pend_q [NUM_CPU];
    logic [NUM_CPU-1:0] srcm_q [NUM_CPU][NUM_SGI];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[c] <= '0;
                for (int s = 0; s < NUM_SGI; s++) srcm_q[c][s] <= '0;
            end else if (set_vld_i[c]) begin
                pend_q[c][set_id_i]    <= 1'b1;
                srcm_q[c][set_id_i]    <= srcm_q[c][set_id_i] | src_i;
            end
        end

        p_all_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_vld_i[c] |=> pend_q[c][$past(set_id_i)]);
        p_src_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
            set_vld_i[c] |=> ((srcm_q[c][$past(set_id_i)] & $past(src_i)) == $past(src_i)));
    end

    assign rb_pend_o = pend_q[rb_cpu_i][rb_sgi_i];
    assign rb_src_o  = srcm_q[rb_cpu_i][rb_sgi_i];
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int CNT_W = $clog2(NUM_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_full,
    input  logic [31:0]        wr_data,
    input  logic [CPU_W-1:0]   src_cpu,
    input  logic [CNT_W-1:0]   online_cnt,
    output logic [31:0]        trig_rdata,
    output logic [NUM_CPU-1:0] set_pend_vld,
    output logic [3:0]         set_pend_id,
    output logic [NUM_CPU-1:0] src_upd,
    input  logic [CPU_W-1:0]   rb_cpu,
    input  logic [3:0]         rb_sgi,
    output logic               rb_pend,
    output logic [NUM_CPU-1:0] rb_src
);
    sgi_state_e         state_q, state_d;
    logic [NUM_CPU-1:0] dec_tgt, tgt_q, src_q;
    logic [ID_W-1:0]    dec_id, id_q;
    logic               dec_drop, accept;

    sgi_tgt_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .word_i (wr_data),
        .src_i  (src_cpu),
        .cnt_i  (online_cnt),
        .tgt_o  (dec_tgt),
        .id_o   (dec_id),
        .drop_o (dec_drop)
    );

    assign accept = wr_en && wr_full && !dec_drop;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;   // GO_ISSUE
            ST_ISSUE: if (!accept) state_d = ST_IDLE;   // BACK_IDLE, else STAY_ISSUE
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
            id_q  <= '0;
            src_q <= '0;
        end else if (accept) begin
            tgt_q <= dec_tgt;
            id_q  <= dec_id;
            src_q <= NUM_CPU'(1) << src_cpu;
        end
    end

    assign set_pend_vld = (state_q == ST_ISSUE) ? tgt_q : '0;
    assign set_pend_id  = id_q;
    assign src_upd      = (state_q == ST_ISSUE) ? src_q : '0;
    assign trig_rdata   = '0;

    sgi_flag_store #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vld_i (set_pend_vld),
        .set_id_i  (set_pend_id),
        .src_i     (src_upd),
        .rb_cpu_i  (rb_cpu),
        .rb_sgi_i  (rb_sgi),
        .rb_pend_o (rb_pend),
        .rb_src_o  (rb_src)
    );

    p_id_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (set_pend_id == $past(wr_data[3:0])));
    p_drop_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[25:24] == 2'd3) |=> (set_pend_vld == '0));
    p_partial_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_full) |=> (set_pend_vld == '0));
    p_onehot_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_pend_vld != '0) |-> $onehot(src_upd));
    p_self_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_data[25:24] == 2'd2) |=> ($countones(set_pend_vld) <= 1));
endmodule

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
    localparam int NUM_CPU = 8;
    localparam int NUM_SGI = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_full = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  src_cpu = '0;
    logic [3:0]  online_cnt = 4'd8;
    logic [31:0] trig_rdata;
    logic [7:0]  set_pend_vld;
    logic [3:0]  set_pend_id;
    logic [7:0]  src_upd;
    logic [2:0]  rb_cpu = '0;
    logic [3:0]  rb_sgi = '0;
    logic        rb_pend;
    logic [7:0]  rb_src;

    int total = 0;
    int bad = 0;
    logic       exp_pend [NUM_CPU][NUM_SGI];
    logic [7:0] exp_src  [NUM_CPU][NUM_SGI];

    always #4 clk = ~clk;

    sgi_dispatch #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_full(wr_full),
        .wr_data(wr_data), .src_cpu(src_cpu), .online_cnt(online_cnt),
        .trig_rdata(trig_rdata), .set_pend_vld(set_pend_vld),
        .set_pend_id(set_pend_id), .src_upd(src_upd),
        .rb_cpu(rb_cpu), .rb_sgi(rb_sgi), .rb_pend(rb_pend), .rb_src(rb_src)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_mask(logic [31:0] d, int src, int cnt);
        logic [7:0] on, m;
        for (int i = 0; i < 8; i++) on[i] = (i < cnt);
        case (d[25:24])
            2'd0: m = d[23:16];
            2'd1: m = ~(8'd1 << src);
            2'd2: m = 8'd1 << src;
            default: m = 8'd0;
        endcase
        return m & on;
    endfunction

    task automatic check_readback(string req, int sgi);
        for (int c = 0; c < NUM_CPU; c++) begin
            rb_cpu = 3'(c);
            rb_sgi = 4'(sgi);
            #1;
            check(req, {31'd0, rb_pend}, {31'd0, exp_pend[c][sgi]});
            check(req, {24'd0, rb_src}, {24'd0, exp_src[c][sgi]});
        end
    endtask

    task automatic do_write(string req, logic [31:0] d, int src, int cnt, logic full);
        logic [7:0] m;
        m = full ? exp_mask(d, src, cnt) : 8'd0;
        @(negedge clk);
        wr_en = 1'b1; wr_full = full; wr_data = d;
        src_cpu = 3'(src); online_cnt = 4'(cnt);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check(req, {24'd0, set_pend_vld}, {24'd0, m});
        if (m != 0) begin
            check({req, "/R1"}, {28'd0, set_pend_id}, {28'd0, d[3:0]});
            check({req, "/R6"}, {24'd0, src_upd}, {24'd0, 8'd1 << src});
            for (int c = 0; c < NUM_CPU; c++)
                if (m[c]) begin
                    exp_pend[c][d[3:0]] = 1'b1;
                    exp_src[c][d[3:0]] |= 8'd1 << src;
                end
        end
        @(posedge clk);
        #1;
        check({req, "/R10"}, {24'd0, set_pend_vld}, 32'd0);
        check_readback({req, "/R10"}, int'(d[3:0]));
    endtask

    task automatic t_reset();
        check("reset vld", {24'd0, set_pend_vld}, 32'd0);
        check_readback("reset", 0);
        check_readback("reset", 15);
    endtask

    task automatic t_read_zero();
        check("R8", trig_rdata, 32'd0);
    endtask

    task automatic t_list();   // R2 R9 R1
        do_write("R2_R9", {6'd0, 2'd0, 8'hFF, 12'd0, 4'd5}, 1, 5, 1'b1);
        do_write("R2", {6'd0, 2'd0, 8'h24, 12'd0, 4'd5}, 0, 8, 1'b1);
        check("R8", trig_rdata, 32'd0);
    endtask

    task automatic t_others(); // R3
        do_write("R3", {6'd0, 2'd1, 8'h00, 12'd0, 4'd7}, 2, 4, 1'b1);
    endtask

    task automatic t_self();   // R4 R6
        do_write("R4_R6", {6'd0, 2'd2, 8'h00, 12'd0, 4'd7}, 3, 8, 1'b1);
    endtask

    task automatic t_reserved(); // R5
        do_write("R5", {6'd0, 2'd3, 8'hFF, 12'd0, 4'd9}, 1, 8, 1'b1);
        do_write("R5", {6'd0, 2'd3, 8'hFF, 12'd0, 4'd7}, 6, 8, 1'b1);
    endtask

    task automatic t_partial(); // R7
        do_write("R7", {6'd0, 2'd0, 8'hFF, 12'd0, 4'd11}, 2, 8, 1'b0);
    endtask

    initial begin
        for (int c = 0; c < NUM_CPU; c++)
            for (int s = 0; s < NUM_SGI; s++) begin
                exp_pend[c][s] = 1'b0;
                exp_src[c][s]  = 8'd0;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_read_zero();
        t_list();
        t_others();
        t_self();
        t_reserved();
        t_partial();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule